// File: doc/BRIEF.md
# Audio Serial Clock Divider

This block turns a fast kernel clock into the bit clock of an audio serial link and, if asked, a master clock for an external converter. It runs entirely in the kernel clock domain. The divided clocks come out as registered levels, together with a one-cycle strobe that marks the start of every bit-clock period. Logic that lives on the kernel clock uses that strobe as an enable.

The base ratio is twice an 8-bit divide value plus a single odd-factor bit. With the master clock off, the bit clock runs at the base ratio. With the master clock on, the master clock takes the base ratio and the bit clock is divided further. The extra factor is 8 for the narrow channel setting and 4 for the wide one.

The sample rate follows from the bit rate divided by the product of bits per channel and channel count, and that arithmetic is left to the user. Settings are captured while the block is stopped. Any change made while it runs waits until the next stop and start.

Top module: `audio_clkgen`

## Requirements
- R1: With `mck_on`=0 and an even ratio N = 2*`div_val`+`odd_add` (N>=2), `bclk` repeats every N kernel cycles, high for N/2 and low for N/2.
- R2: For an odd ratio N>=3, the high phase of the base clock lasts (N-1)/2 cycles and the low phase lasts (N+1)/2 cycles.
- R3: With `mck_on`=1 and `wide_chan`=0, `bclk` repeats every 8*N cycles and is high for the first 4*N of them.
- R4: With `mck_on`=1 and `wide_chan`=1, `bclk` repeats every 4*N cycles and is high for the first 2*N of them.
- R5: With `mck_on`=1, `mclk` is the base clock of ratio N, in phase with the start of each `bclk` period. With `mck_on`=0, `mclk` stays low.
- R6: A captured ratio below 2 (`div_val`=0) keeps `bclk`, `mclk` and `bclk_stb` low while enabled.
- R7: Changes to `div_val`, `odd_add`, `mck_on` or `wide_chan` while running do not affect the outputs. They take effect after `enable` goes low and high again.
- R8: While stopped, all outputs are low. In the first cycle after the clock edge that samples `enable` high, the counters start from zero, `bclk` is high and `bclk_stb` is 1.
- R9: `bclk_stb` is high for exactly one cycle at the start of every `bclk` period, and only while `bclk` is high.
- R10: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; rising use captures the settings |
| div_val | input | 8 | Divide value; ratio = 2*div_val + odd_add |
| odd_add | input | 1 | Adds one to the ratio |
| mck_on | input | 1 | Enables the master clock and the post-divide |
| wide_chan | input | 1 | Post-divide select: 0 gives 8, 1 gives 4 |
| bclk | output | 1 | Bit clock level |
| bclk_stb | output | 1 | One-cycle strobe at each bit-clock period start |
| mclk | output | 1 | Master clock level |

## Verification
The hardest case to reach is a settings change in the middle of a long running period, because the outputs must keep their old rhythm. The stimulus rewrites every setting with random values halfway through several runs. It then keeps checking against the captured ratio until the next stop and start. The longest ratio (511 with the wide post-divide) runs for more than a full bit period, which covers counter wrap at the top of the range. The ratios 0 and 1 are driven directly to cover the idle rule.

// File: rtl/acg_pkg.sv
package acg_pkg;
    localparam int DIV_W      = 8;
    localparam int RATIO_W    = DIV_W + 1;
    localparam int NARROW_DIV = 8;
    localparam int WIDE_DIV   = 4;
    localparam int POST_W     = $clog2(NARROW_DIV);
    localparam int PLEN_W     = POST_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             odd;
        logic             mck;
        logic             wide;
    } cfg_t;

    typedef struct packed {
        logic               run;
        cfg_t               cfg;
        logic [RATIO_W-1:0] cnt;
        logic [POST_W-1:0]  post;
    } state_t;
endpackage

// File: rtl/acg_ratio_calc.sv
module acg_ratio_calc
    import acg_pkg::*;
(
    input  cfg_t               cfg,
    output logic [RATIO_W-1:0] ratio_last,
    output logic [RATIO_W-1:0] ratio_half,
    output logic               ratio_ok,
    output logic [POST_W-1:0]  post_last,
    output logic [POST_W-1:0]  post_half
);
    logic [RATIO_W-1:0] ratio;
    logic [PLEN_W-1:0]  plen;

    always_comb begin
        ratio      = {cfg.div, cfg.odd};
        ratio_ok   = (ratio >= RATIO_W'(2));
        ratio_last = ratio - RATIO_W'(1);
        ratio_half = ratio >> 1;
        plen       = cfg.wide ? PLEN_W'(WIDE_DIV) : PLEN_W'(NARROW_DIV);
        post_last  = POST_W'(plen - PLEN_W'(1));
        post_half  = POST_W'(plen >> 1);
    end
endmodule

// File: rtl/acg_phase_decode.sv
module acg_phase_decode
    import acg_pkg::*;
(
    input  state_t             st,
    input  logic               ratio_ok,
    input  logic [RATIO_W-1:0] ratio_half,
    input  logic [POST_W-1:0]  post_half,
    output logic               bclk,
    output logic               mclk,
    output logic               bclk_stb
);
    logic live;
    logic base_hi;

    always_comb begin
        live     = st.run & ratio_ok;
        base_hi  = live & (st.cnt < ratio_half);
        mclk     = base_hi & st.cfg.mck;
        bclk     = st.cfg.mck ? (live & (st.post < post_half)) : base_hi;
        bclk_stb = live & (st.cnt == '0) & (~st.cfg.mck | (st.post == '0));
    end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import acg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_val,
    input  logic             odd_add,
    input  logic             mck_on,
    input  logic             wide_chan,
    output logic             bclk,
    output logic             bclk_stb,
    output logic             mclk
);
    state_t st_d, st_q;
    cfg_t   cfg_in;

    logic [RATIO_W-1:0] ratio_last;
    logic [RATIO_W-1:0] ratio_half;
    logic               ratio_ok;
    logic [POST_W-1:0]  post_last;
    logic [POST_W-1:0]  post_half;

    // Probes for the bound checker.
    logic                 run_q;
    logic [DIV_W+2:0]     cfg_bits;
    assign run_q    = st_q.run;
    assign cfg_bits = st_q.cfg;

    assign cfg_in = '{div: div_val, odd: odd_add, mck: mck_on, wide: wide_chan};

    acg_ratio_calc u_ratio (
        .cfg        (st_q.cfg),
        .ratio_last (ratio_last),
        .ratio_half (ratio_half),
        .ratio_ok   (ratio_ok),
        .post_last  (post_last),
        .post_half  (post_half)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            // Stopped: track settings so the enabling edge captures them.
            st_d.cfg  = cfg_in;
            st_d.run  = enable;
            st_d.cnt  = '0;
            st_d.post = '0;
        end else if (!enable) begin
            st_d.run  = 1'b0;
            st_d.cnt  = '0;
            st_d.post = '0;
        end else if (ratio_ok) begin
            if (st_q.cnt == ratio_last) begin
                st_d.cnt = '0;
                if (st_q.cfg.mck) begin
                    st_d.post = (st_q.post == post_last) ? '0 : st_q.post + POST_W'(1);
                end
            end else begin
                st_d.cnt = st_q.cnt + RATIO_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    acg_phase_decode u_phase (
        .st         (st_q),
        .ratio_ok   (ratio_ok),
        .ratio_half (ratio_half),
        .post_half  (post_half),
        .bclk       (bclk),
        .mclk       (mclk),
        .bclk_stb   (bclk_stb)
    );
endmodule

// File: rtl/acg_checker.sv
module acg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       mck_on,
    input logic       bclk,
    input logic       bclk_stb,
    input logic       mclk,
    input logic       run_q,
    input logic [10:0] cfg_bits
);
    // R8: a stop request idles every output on the next cycle
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bclk && !mclk && !bclk_stb));

    // R9: the strobe only appears while the bit clock is high
    a_r9_stb_high: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_stb |-> bclk);

    // R9: every rise of the bit clock carries the strobe
    a_r9_rise_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> bclk_stb);

    // R5: starting with the master clock off keeps it low
    a_r5_mclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !mck_on) |=> !mclk);

    // R7: captured settings hold while running
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> $stable(cfg_bits));
endmodule

bind audio_clkgen acg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .mck_on   (mck_on),
    .bclk     (bclk),
    .bclk_stb (bclk_stb),
    .mclk     (mclk),
    .run_q    (run_q),
    .cfg_bits (cfg_bits)
);

// File: tb/audio_clkgen_tb_top.sv
`timescale 1ns/1ps
module audio_clkgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] div_val = '0;
    logic       odd_add = 1'b0;
    logic       mck_on = 1'b0;
    logic       wide_chan = 1'b0;
    logic       bclk, bclk_stb, mclk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    audio_clkgen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_val(div_val),
        .odd_add(odd_add), .mck_on(mck_on), .wide_chan(wide_chan),
        .bclk(bclk), .bclk_stb(bclk_stb), .mclk(mclk)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected {bclk, mclk, stb} in cycle n after the enabling edge.
    function automatic logic [2:0] expect_out(input int r, input int mc, input int wd, input int n);
        int p, c, q;
        logic b, m, s;
        if (r < 2) return 3'b000;
        p = mc ? (wd ? 4 : 8) : 1;
        c = n % r;
        q = (n / r) % p;
        m = mc ? (c < r / 2) : 1'b0;
        b = mc ? (q < p / 2) : (c < r / 2);
        s = (c == 0) && (q == 0);
        return {b, m, s};
    endfunction

    task automatic run_case(input int dv, input int od, input int mc, input int wd, input bit perturb);
        int r, p, len;
        string tag;
        logic [2:0] e;
        r = 2 * dv + od;
        p = mc ? (wd ? 4 : 8) : 1;
        len = (r < 2) ? 20 : ((2 * p * r + 3 > 2500) ? 2500 : 2 * p * r + 3);
        if (r < 2)      tag = "R6";
        else if (mc != 0) tag = wd ? "R4" : "R3";
        else            tag = (r % 2 != 0) ? "R2" : "R1";
        if (perturb) tag = "R7";
        @(posedge clk); #1;
        enable = 1'b0; div_val = 8'(dv); odd_add = od[0]; mck_on = mc[0]; wide_chan = wd[0];
        @(posedge clk); #1;
        check("R8 stopped bclk", bclk, 1'b0);
        check("R8 stopped mclk", mclk, 1'b0);
        check("R8 stopped stb", bclk_stb, 1'b0);
        enable = 1'b1;
        @(posedge clk); #1;
        for (int n = 0; n < len; n++) begin
            e = expect_out(r, mc, wd, n);
            check(tag, bclk, e[2]);
            check("R5 mclk", mclk, e[1]);
            check("R9 stb", bclk_stb, e[0]);
            if (perturb && n == len / 2) begin
                div_val = 8'($urandom % 256); odd_add = 1'($urandom);
                mck_on = 1'($urandom); wide_chan = 1'($urandom);
            end
            @(posedge clk); #1;
        end
    endtask

    initial begin
        int s;
        s = $urandom(17);
        #1;
        check("R10 reset bclk", bclk, 1'b0);
        check("R10 reset mclk", mclk, 1'b0);
        check("R10 reset stb", bclk_stb, 1'b0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        run_case(0, 0, 0, 0, 1'b0);   // R6 ratio 0
        run_case(0, 1, 1, 0, 1'b0);   // R6 ratio 1
        run_case(1, 0, 0, 0, 1'b0);   // R1 smallest ratio
        run_case(1, 1, 0, 0, 1'b0);   // R2 ratio 3
        run_case(1, 1, 1, 0, 1'b0);   // R3
        run_case(2, 0, 1, 1, 1'b0);   // R4
        run_case(255, 1, 1, 1, 1'b0); // R4 largest ratio
        run_case(3, 1, 0, 0, 1'b1);   // R7 change mid-run
        run_case(2, 1, 1, 1, 1'b0);   // R7 new settings after restart
        for (int i = 0; i < 16; i++) begin
            run_case($urandom % 12, $urandom % 2, $urandom % 2, $urandom % 2, 1'($urandom % 3 == 0));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule